// File: doc/BRIEF.md
# Pulse-Train Transmitter with Carrier

This block replays a list of timed output levels onto a single pin. Each list entry is a 16-bit word held in a memory outside the block. The word gives one output level and how long to hold it, counted in ticks of a programmable prescaler. The block reads the list through a simple address/data port. It walks the list from the first word after a start pulse and drives the pin level for level. A carrier can be laid over the entries of one chosen level, so that those intervals become a burst of pulses with programmable high and low times.

A transfer ends at a zero-duration word, or at the last memory address when address wrapping is off. In continuous mode the list instead restarts from the first word and repeats. Address wrapping lets software refill the memory during a long transfer. A count of completed entries raises a threshold event when it passes a programmable limit, and software uses that event to know which part of the memory is free to overwrite.

Outside a transfer, the pin shows a programmable idle level. Two interrupt sources are provided, transfer-done and threshold. Each has a raw flag, an enable and a write-one-to-clear input.

Top module: `pulse_tx`

## Requirements
- R1: A start pulse while idle begins a transfer that fetches the word at address 0 first. A start pulse during a transfer has no effect on the output.
- R2: Entry word format: bit 15 is the level and bits 14:0 are the duration in ticks. One tick lasts cfg_div_i+1 clock cycles, so an entry drives its level for duration*(cfg_div_i+1) cycles.
- R3: Every entry is read in one fetch cycle. During that cycle the pin keeps the previous entry's level; for the first fetch after start it keeps the idle value.
- R4: With continuous mode off, reading a zero-duration word ends the transfer. On the next cycle the pin shows the idle value and the done flag is set.
- R5: With continuous mode on, a zero-duration word sends playback back to address 0. That costs one extra fetch cycle holding the previous level. The transfer repeats and never sets the done flag.
- R6: When the carrier is on, entries of the modulated level output carrier high for max(cfg_car_high_i,1) cycles, then low for max(cfg_car_low_i,1) cycles, repeating. Each such entry starts with a full high phase. cfg_car_on_low_i=1 modulates level-0 entries and 0 modulates level-1 entries.
- R7: Entries of the other level, and all entries when the carrier is off, drive their level steadily.
- R8: The threshold flag (irq_raw_o[1]) sets once per transfer, on the completion that brings the count of completed entries to cfg_limit_i+1.
- R9: After the entry at the last memory address, the address goes back to 0. With wrapping and continuous mode both off, the transfer ends on that entry's completion: the idle value and the done flag appear in the next cycle.
- R10: While idle the pin equals cfg_idle_lvl_i when cfg_idle_en_i is 1, and 0 otherwise.
- R11: irq_raw_o[0] is the done flag and irq_raw_o[1] the threshold flag. An event sets its flag, and writing 1 to the matching irq_clr_i bit clears it. irq_o is the OR of the flags masked by irq_ena_i.
- R12: A pulse on rd_ptr_rst_i resets the read address to 0, so the next fetch reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rd_ptr_rst_i | input | 1 | Read address reset pulse |
| cfg_div_i | input | DIV_W | Prescaler: tick every cfg_div_i+1 cycles |
| cfg_loop_i | input | 1 | Continuous mode |
| cfg_wrap_i | input | 1 | Continue at address 0 after the last address |
| cfg_car_en_i | input | 1 | Carrier enable |
| cfg_car_on_low_i | input | 1 | 1: modulate level-0 entries, 0: level-1 entries |
| cfg_car_high_i | input | 16 | Carrier high time in cycles |
| cfg_car_low_i | input | 16 | Carrier low time in cycles |
| cfg_limit_i | input | LIM_W | Threshold limit on completed entries |
| cfg_idle_en_i | input | 1 | Idle level enable |
| cfg_idle_lvl_i | input | 1 | Idle level |
| irq_ena_i | input | 2 | Interrupt enables |
| irq_clr_i | input | 2 | Write-one-to-clear for the raw flags |
| mem_addr_o | output | ADDR_W | List memory read address |
| mem_data_i | input | 16 | List memory read data (same cycle) |
| tx_o | output | 1 | Output pin |
| busy_o | output | 1 | Transfer in progress |
| irq_raw_o | output | 2 | Raw flags: bit 0 done, bit 1 threshold |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench computes the full expected pin waveform of each transfer, sample by sample, and compares it against the design. Short lists at prescaler settings 0, 1 and 2 separate tick counting from fetch-cycle placement. Carrier runs with each level selected, and with zero phase lengths, separate the modulation level choice from phase counting and from the restart at each entry. Continuous, wrapping and non-wrapping runs over the whole memory distinguish the three ways a list can end or continue. A read-address reset and a repeated start in mid-transfer show whether control pulses are honoured or ignored.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int WORD_W = 16;
  localparam int DUR_W  = WORD_W - 1;
  localparam int CAR_W  = 16;
  localparam int IRQ_N  = 2;
  localparam int IRQ_DONE = 0;
  localparam int IRQ_THR  = 1;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_RUN   = 2'd2
  } seq_state_e;

  // level bit of a list word
  function automatic logic word_level(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  // duration field of a list word, in ticks
  function automatic logic [DUR_W-1:0] word_dur(input logic [WORD_W-1:0] w);
    return w[DUR_W-1:0];
  endfunction

  // a programmed phase length of zero behaves as one cycle
  function automatic logic [CAR_W-1:0] phase_len(input logic [CAR_W-1:0] n);
    return (n == '0) ? CAR_W'(1) : n;
  endfunction
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pt_carrier.sv
module pt_carrier
  import pt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CAR_W-1:0] hi_len,
  input  logic [CAR_W-1:0] lo_len,
  output logic             phase
);
  logic [CAR_W-1:0] cnt;
  logic [CAR_W-1:0] lim;

  assign lim = phase ? phase_len(hi_len) : phase_len(lo_len);

  // held in the high phase while inactive, so each interval starts high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (!active) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt >= lim - CAR_W'(1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pt_irq.sv
module pt_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ena,
  output logic [N-1:0] raw,
  output logic         irq
);
  // an event in the same cycle as its clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= evt | (raw & ~clr);
  end

  assign irq = |(raw & ena);
endmodule

// File: rtl/pulse_tx.sv
module pulse_tx
  import pt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 8,
  parameter int LIM_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     rd_ptr_rst_i,
  input  logic [DIV_W-1:0]         cfg_div_i,
  input  logic                     cfg_loop_i,
  input  logic                     cfg_wrap_i,
  input  logic                     cfg_car_en_i,
  input  logic                     cfg_car_on_low_i,
  input  logic [pt_pkg::CAR_W-1:0] cfg_car_high_i,
  input  logic [pt_pkg::CAR_W-1:0] cfg_car_low_i,
  input  logic [LIM_W-1:0]         cfg_limit_i,
  input  logic                     cfg_idle_en_i,
  input  logic                     cfg_idle_lvl_i,
  input  logic [pt_pkg::IRQ_N-1:0] irq_ena_i,
  input  logic [pt_pkg::IRQ_N-1:0] irq_clr_i,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [pt_pkg::WORD_W-1:0] mem_data_i,
  output logic                     tx_o,
  output logic                     busy_o,
  output logic [pt_pkg::IRQ_N-1:0] irq_raw_o,
  output logic                     irq_o
);
  localparam int CNT_W = LIM_W + 1;

  seq_state_e        st;
  logic [ADDR_W-1:0] ptr;
  logic              lvl_q;
  logic [DUR_W-1:0]  rem;
  logic              last_q;
  logic [CNT_W-1:0]  sent;

  // named internal events, also seen by the checker
  logic              st_idle;
  logic              accept;
  logic              fetch;
  logic              f_lvl;
  logic [DUR_W-1:0]  f_dur;
  logic              f_marker;
  logic              tick;
  logic              ent_done;
  logic              ev_done;
  logic              ev_thr;
  logic              idle_val;
  logic              car_active;
  logic              car_phase;
  logic [IRQ_N-1:0]  evt_vec;

  assign st_idle  = (st == S_IDLE);
  assign accept   = st_idle && start_i;
  assign fetch    = (st == S_FETCH);
  assign f_lvl    = word_level(mem_data_i);
  assign f_dur    = word_dur(mem_data_i);
  assign f_marker = fetch && (f_dur == '0);
  assign ent_done = tick && (rem == DUR_W'(1));
  assign ev_done  = (f_marker && !cfg_loop_i) || (ent_done && last_q);
  assign ev_thr   = ent_done && (sent == {1'b0, cfg_limit_i});
  assign idle_val = cfg_idle_en_i & cfg_idle_lvl_i;

  pt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st == S_RUN),
    .div  (cfg_div_i),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      lvl_q  <= 1'b0;
      rem    <= '0;
      last_q <= 1'b0;
      sent   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            st     <= S_FETCH;
            ptr    <= '0;
            lvl_q  <= idle_val;
            sent   <= '0;
            last_q <= 1'b0;
          end
        end
        S_FETCH: begin
          if (f_dur == '0) begin
            if (cfg_loop_i) ptr <= '0;
            else            st  <= S_IDLE;
          end else begin
            st     <= S_RUN;
            lvl_q  <= f_lvl;
            rem    <= f_dur;
            ptr    <= ptr + 1'b1;
            last_q <= (&ptr) && !cfg_wrap_i && !cfg_loop_i;
          end
        end
        S_RUN: begin
          if (tick) begin
            if (rem == DUR_W'(1)) begin
              if (sent <= {1'b0, cfg_limit_i}) sent <= sent + 1'b1;
              st <= last_q ? S_IDLE : S_FETCH;
            end else begin
              rem <= rem - 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (rd_ptr_rst_i) ptr <= '0;
    end
  end

  assign car_active = (st == S_RUN) && cfg_car_en_i && (lvl_q == !cfg_car_on_low_i);

  pt_carrier u_car (
    .clk   (clk),
    .rst_n (rst_n),
    .active(car_active),
    .hi_len(cfg_car_high_i),
    .lo_len(cfg_car_low_i),
    .phase (car_phase)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[IRQ_DONE] = ev_done;
    evt_vec[IRQ_THR]  = ev_thr;
  end

  pt_irq #(.N(IRQ_N)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt_vec),
    .clr  (irq_clr_i),
    .ena  (irq_ena_i),
    .raw  (irq_raw_o),
    .irq  (irq_o)
  );

  assign mem_addr_o = ptr;
  assign busy_o     = !st_idle;
  assign tx_o       = st_idle ? idle_val : (car_active ? car_phase : lvl_q);
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_ptr_rst_i,
  input logic              st_idle,
  input logic              ev_done,
  input logic              ev_thr,
  input logic              car_active,
  input logic              tx_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        irq_raw_o,
  input logic [1:0]        irq_clr_i
);
  logic thr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   thr_seen <= 1'b0;
    else if (st_idle && start_i)  thr_seen <= 1'b0;
    else if (ev_thr)              thr_seen <= 1'b1;
  end

  assert_start_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && start_i) |=> (mem_addr_o == '0));

  assert_done_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> st_idle);

  assert_carrier_high_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(car_active) |-> tx_o);

  assert_thr_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thr |=> irq_raw_o[1]);

  assert_thr_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thr |-> !thr_seen);

  assert_done_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> irq_raw_o[0]);

  assert_done_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i[0] && !ev_done) |=> !irq_raw_o[0]);

  assert_ptr_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_rst_i |=> (mem_addr_o == '0));
endmodule

bind pulse_tx pt_checker #(.ADDR_W(ADDR_W)) u_pt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rd_ptr_rst_i(rd_ptr_rst_i),
  .st_idle     (st_idle),
  .ev_done     (ev_done),
  .ev_thr      (ev_thr),
  .car_active  (car_active),
  .tx_o        (tx_o),
  .mem_addr_o  (mem_addr_o),
  .irq_raw_o   (irq_raw_o),
  .irq_clr_i   (irq_clr_i)
);

// File: tb/tb_pulse_tx.sv
module tb_pulse_tx;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 160;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ptr_rst = 1'b0;
  logic [7:0]  div;
  logic        loop_m, wrap_m, car_en, car_low;
  logic [15:0] car_hi, car_lo;
  logic [8:0]  limit;
  logic        idle_en, idle_lvl;
  logic [1:0]  ena, clr;
  logic [3:0]  mem_addr;
  logic [15:0] mem_data;
  logic        tx, busy, irq;
  logic [1:0]  raw;

  logic [15:0] mem [DEPTH];
  assign mem_data = mem[mem_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_ptr_rst_i(ptr_rst),
    .cfg_div_i(div), .cfg_loop_i(loop_m), .cfg_wrap_i(wrap_m),
    .cfg_car_en_i(car_en), .cfg_car_on_low_i(car_low),
    .cfg_car_high_i(car_hi), .cfg_car_low_i(car_lo), .cfg_limit_i(limit),
    .cfg_idle_en_i(idle_en), .cfg_idle_lvl_i(idle_lvl),
    .irq_ena_i(ena), .irq_clr_i(clr), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .tx_o(tx), .busy_o(busy),
    .irq_raw_o(raw), .irq_o(irq)
  );

  int total = 0;
  int fails = 0;
  logic exp_tx [MAXS];
  logic act_tx [MAXS];
  logic act_r0 [MAXS];
  logic act_r1 [MAXS];
  logic [3:0] act_addr [MAXS];
  int done_at, thr_at, gk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    div = 0; loop_m = 0; wrap_m = 0; car_en = 0; car_low = 0;
    car_hi = 0; car_lo = 0; limit = 9'd511; idle_en = 0; idle_lvl = 0;
    ena = 0; clr = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] ent(input logic l, input int d);
    return {l, d[14:0]};
  endfunction

  task automatic put(input logic v);
    if (gk < MAXS) exp_tx[gk] = v;
    gk++;
  endtask

  // expected pin waveform, one value per clock after the start edge
  task automatic gen();
    int p = 0;
    int ndone = 0;
    int h, lo_c, per, len;
    logic prev, iv, l, md;
    iv = idle_en & idle_lvl;
    h = (car_hi == 0) ? 1 : int'(car_hi);
    lo_c = (car_lo == 0) ? 1 : int'(car_lo);
    per = h + lo_c;
    for (int i = 0; i < MAXS; i++) exp_tx[i] = iv;
    done_at = MAXS; thr_at = MAXS; gk = 0;
    prev = iv;
    put(prev);
    while (gk < MAXS) begin
      len = int'(mem[p][14:0]);
      l = mem[p][15];
      if (len == 0) begin
        if (loop_m) begin p = 0; put(prev); continue; end
        done_at = gk; break;
      end
      md = car_en && (l == !car_low);
      for (int j = 0; j < len * (int'(div) + 1); j++)
        put(md ? ((j % per) < h) : l);
      ndone++;
      if (ndone == int'(limit) + 1) thr_at = gk;
      if (p == DEPTH - 1) begin
        p = 0;
        if (!wrap_m && !loop_m) begin done_at = gk; break; end
      end else p++;
      put(l);
      prev = l;
    end
  endtask

  task automatic capture(int n, int rst_at, int restart_at);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      act_tx[k] = tx; act_r0[k] = raw[0]; act_r1[k] = raw[1];
      act_addr[k] = mem_addr;
      ptr_rst = (k == rst_at);
      start = (k == restart_at);
      @(negedge clk);
    end
    ptr_rst = 1'b0;
    start = 1'b0;
  endtask

  task automatic cmp_trace(string tag, int n);
    int btx = -1, b0 = -1, b1 = -1;
    for (int k = 0; k < n; k++) begin
      if (act_tx[k] !== exp_tx[k] && btx < 0) btx = k;
      if (act_r0[k] !== (k >= done_at) && b0 < 0) b0 = k;
      if (act_r1[k] !== (k >= thr_at) && b1 < 0) b1 = k;
    end
    total += 3;
    if (btx >= 0) begin
      fails++;
      $display("FAIL %s pin sample %0d actual=%0b expected=%0b", tag, btx, act_tx[btx], exp_tx[btx]);
    end
    if (b0 >= 0) begin
      fails++;
      $display("FAIL %s R11 done flag sample %0d actual=%0b expected=%0b", tag, b0, act_r0[b0], b0 >= done_at);
    end
    if (b1 >= 0) begin
      fails++;
      $display("FAIL %s R8 threshold flag sample %0d actual=%0b expected=%0b", tag, b1, act_r1[b1], b1 >= thr_at);
    end
  endtask

  task automatic run_case(string tag, int n);
    gen();
    capture(n, -1, -1);
    cmp_trace(tag, n);
    do_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int first_done;
    defaults();
    do_reset();

    // reset state and idle level (R10)
    chk("R10 reset pin", tx, 0);
    chk("R11 reset raw", raw, 0);
    chk("R11 reset irq", irq, 0);
    chk("R1 reset busy", busy, 0);
    idle_en = 1; idle_lvl = 1; #1;
    chk("R10 idle enabled high", tx, 1);
    idle_lvl = 0; #1;
    chk("R10 idle enabled low", tx, 0);
    idle_en = 0; idle_lvl = 1; #1;
    chk("R10 idle disabled", tx, 0);
    idle_lvl = 0;

    // basic list, no prescale (R1 R2 R3 R4)
    mem[0] = ent(1, 3); mem[1] = ent(0, 2); mem[2] = ent(1, 1); mem[3] = ent(0, 0);
    run_case("R1 R2 R3 R4 basic", 16);

    // start again mid-transfer is ignored (R1)
    gen();
    capture(16, -1, 5);
    cmp_trace("R1 restart ignored", 16);
    do_reset();

    // prescaler 2 and high idle level (R2 R10)
    div = 2; idle_en = 1; idle_lvl = 1;
    mem[0] = ent(0, 2); mem[1] = ent(1, 3); mem[2] = ent(0, 0);
    run_case("R2 R10 prescale", 26);

    // carrier on level-1 entries (R6 R7)
    defaults();
    div = 1; car_en = 1; car_low = 0; car_hi = 2; car_lo = 1;
    mem[0] = ent(1, 5); mem[1] = ent(0, 3); mem[2] = ent(1, 2); mem[3] = ent(0, 0);
    run_case("R6 R7 carrier high level", 30);

    // carrier on level-0 entries (R6 R7)
    defaults();
    car_en = 1; car_low = 1; car_hi = 1; car_lo = 3;
    mem[0] = ent(0, 9); mem[1] = ent(1, 2); mem[2] = ent(0, 4); mem[3] = ent(0, 0);
    run_case("R6 R7 carrier low level", 24);

    // zero phase lengths act as one cycle (R6)
    defaults();
    car_en = 1; car_hi = 0; car_lo = 0;
    mem[0] = ent(1, 6); mem[1] = ent(0, 0);
    run_case("R6 zero phase lengths", 12);

    // continuous mode (R5)
    defaults();
    loop_m = 1;
    mem[0] = ent(1, 2); mem[1] = ent(0, 3); mem[2] = ent(0, 0);
    run_case("R5 continuous", 60);

    // threshold reached (R8)
    defaults();
    limit = 2;
    for (int i = 0; i < 5; i++) mem[i] = ent(i[0], i + 1);
    run_case("R8 threshold at limit", 30);

    // threshold never reached (R8)
    limit = 7;
    run_case("R8 threshold beyond list", 30);

    // whole memory without wrap ends at last address (R9)
    defaults();
    for (int i = 0; i < DEPTH; i++) mem[i] = ent(i[0], 1 + (i % 2));
    run_case("R9 end of memory", 50);

    // whole memory with wrap keeps going (R9)
    wrap_m = 1;
    run_case("R9 wrap", 100);

    // read address reset mid-transfer (R12)
    defaults();
    mem[0] = ent(1, 4); mem[1] = ent(0, 4); mem[2] = ent(1, 4); mem[3] = ent(0, 0);
    capture(40, 7, -1);
    chk("R12 address after reset pulse", act_addr[8], 0);
    first_done = -1;
    for (int k = 0; k < 40; k++) if (act_r0[k] && first_done < 0) first_done = k;
    chk("R12 done after replay from address 0", first_done, 26);
    // done flag still set here: masking and clearing (R11)
    chk("R11 masked irq off", irq, 0);
    ena = 2'b01; #1;
    chk("R11 done enabled irq", irq, 1);
    ena = 2'b10; #1;
    chk("R11 other enable only", irq, 0);
    ena = 2'b01;
    clr = 2'b01;
    @(negedge clk);
    clr = 2'b00;
    chk("R11 write-one clears raw", raw[0], 0);
    chk("R11 irq drops after clear", irq, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule